// File: doc/BRIEF.md
# Programmable Execute Pulse Sequencer

This block produces single-cycle "execute" strobes for a timing card running from a 40 MHz clock. A 2-bit mode code picks the behaviour. Mode 0 gives one strobe each time the run control rises. Mode 1 gives a continuous train of strobes that a button press switches on and off. Mode 2 gives a burst of strobes that a button press starts. Mode 3 gives a burst that a button press arms and the next second tick starts.

The spacing between strobes comes from a 2-bit interval code in decade steps. The length of a burst comes from a 2-bit count code. A status output is high while the sequencer is armed or producing strobes, and it can drive an indicator LED directly.

Holding run low stops the sequencer at once and returns it to its idle state. The button input is a one-cycle event that has already been debounced. The time base is a parameter: the number of clock cycles in 0.1 ms, which is 4000 at 40 MHz.

Top module: `xqt_sequencer`

## Requirements
- R1: After reset, `exec_o` and `busy_o` are 0, and continuous generation is off: in mode 1 with `run` high and no button event, no strobe appears.
- R2: In mode 0, a cycle in which `run` is 1 after a cycle in which it was 0 gives exactly one strobe, on the clock edge that samples it. Holding `run` high gives no more strobes.
- R3: Interval code k sets the spacing between consecutive strobes to `BASE_CYCLES`·10^k clock cycles. The codes 0, 1, 2 and 3 give 0.1 ms, 1 ms, 10 ms and 100 ms.
- R4: Count code 0, 1, 2 or 3 sets the burst length to 2, 10, 100 or 1000 strobes respectively.
- R5: In mode 2, a button event sampled while idle gives the first strobe on that edge. `busy_o` then stays high for exactly burst length × spacing cycles and falls after that. Button events during a burst have no effect.
- R6: In mode 1, a button event while idle starts strobes at the selected spacing, with the first on that edge. The next button event stops them, and `busy_o` goes low.
- R7: In mode 3, a button event arms the sequencer. `busy_o` goes high and no strobe appears until a second tick is sampled. That edge gives the first strobe, and the burst then proceeds as in R5.
- R8: A cycle with `run` at 0 forces `exec_o` and `busy_o` to 0 on the next edge and discards any burst, arming or continuous state.
- R9: Every strobe on `exec_o` is exactly one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle second marker |
| mode | input | 2 | 0 single, 1 continuous, 2 burst, 3 second-aligned burst |
| ivl_sel | input | 2 | Spacing code (decade steps from 0.1 ms) |
| cnt_sel | input | 2 | Burst length code (2, 10, 100, 1000) |
| run | input | 1 | Enable; a rising edge fires in mode 0 |
| btn | input | 1 | Debounced button event, one cycle |
| exec_o | output | 1 | Execute strobe |
| busy_o | output | 1 | Armed or generating; drives the indicator |

## Verification
The hardest situation to reach is the end of a long burst. The 1000-strobe case, or the 100 ms spacing, would need millions of cycles at the real time base. The bench therefore sets `BASE_CYCLES` to 3, which keeps every code combination short. The burst-length and spacing arithmetic stays exactly as it is at full scale.

Button events are also injected in the middle of a burst, and `run` is dropped while a burst is in progress. This shows that the burst end still falls exactly on the expected cycle, and that a stop clears the continuous-mode state as well.

// File: rtl/xqt_pkg.sv
package xqt_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_CONT   = 2'd1,
    XM_BURST  = 2'd2,
    XM_SYNC   = 2'd3
  } xqt_mode_e;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ARMED = 2'd1,
    XS_RUN   = 2'd2
  } xqt_state_e;

  // Cycles between strobes: base * 10^sel
  function automatic int unsigned spacing_cycles(int unsigned base, logic [1:0] sel);
    int unsigned v;
    v = base;
    for (int i = 0; i < 3; i++) begin
      if (i < int'(sel)) v = v * 10;
    end
    return v;
  endfunction

  // Strobes per burst
  function automatic int unsigned burst_size(logic [1:0] sel);
    case (sel)
      2'd0:    return 2;
      2'd1:    return 10;
      2'd2:    return 100;
      default: return 1000;
    endcase
  endfunction

endpackage

// File: rtl/xqt_gap_timer.sv
module xqt_gap_timer #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expired
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (cnt != '0)       cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/xqt_burst_counter.sv
module xqt_burst_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left_q <= '0;
    else if (clr)                   left_q <= '0;
    else if (load)                  left_q <= load_val;
    else if (dec && left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign last = (left_q == '0);
endmodule

// File: rtl/xqt_ctrl.sv
module xqt_ctrl
  import xqt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] mode,
  input  logic       btn,
  input  logic       sec_tick,
  input  logic       gap_expired,
  input  logic       left_zero,
  output logic       fire,
  output logic       start,
  output logic       step,
  output logic       halt,
  output logic       start_single,
  output logic       waiting,
  output logic       exec_o,
  output logic       busy_o
);
  xqt_state_e state_q, state_d;
  xqt_mode_e  m;
  logic       run_q, run_rise;

  assign m        = xqt_mode_e'(mode);
  assign run_rise = run & ~run_q;

  always_comb begin
    state_d      = state_q;
    fire         = 1'b0;
    start        = 1'b0;
    step         = 1'b0;
    start_single = 1'b0;
    if (!run) begin
      state_d = XS_IDLE;
    end else begin
      case (state_q)
        XS_IDLE: begin
          case (m)
            XM_SINGLE: begin
              start_single = run_rise;
              fire         = run_rise;
            end
            XM_CONT, XM_BURST: if (btn) begin
              state_d = XS_RUN;
              fire    = 1'b1;
              start   = 1'b1;
            end
            default: if (btn) state_d = XS_ARMED;
          endcase
        end
        XS_ARMED: if (sec_tick) begin
          state_d = XS_RUN;
          fire    = 1'b1;
          start   = 1'b1;
        end
        default: begin
          if (m == XM_CONT) begin
            if (btn)              state_d = XS_IDLE;
            else if (gap_expired) fire = 1'b1;
          end else if (gap_expired) begin
            if (left_zero) state_d = XS_IDLE;
            else begin
              fire = 1'b1;
              step = 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign halt    = !run;
  assign waiting = (state_q == XS_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      run_q   <= 1'b0;
      exec_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run;
      exec_o  <= fire;
    end
  end

  assign busy_o = (state_q != XS_IDLE) | exec_o;
endmodule

// File: rtl/xqt_sequencer.sv
module xqt_sequencer
  import xqt_pkg::*;
#(
  parameter int BASE_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [1:0] mode,
  input  logic [1:0] ivl_sel,
  input  logic [1:0] cnt_sel,
  input  logic       run,
  input  logic       btn,
  output logic       exec_o,
  output logic       busy_o
);
  localparam int MAX_GAP = BASE_CYCLES * 1000;
  localparam int GAP_W   = $clog2(MAX_GAP + 1);
  localparam int CNT_W   = $clog2(1000);

  logic             fire, start, step, halt;
  logic             start_single, waiting;
  logic             gap_expired, left_zero;
  logic [GAP_W-1:0] gap_cnt, gap_load;
  logic [CNT_W-1:0] cnt_load;

  assign gap_load = GAP_W'(spacing_cycles(BASE_CYCLES, ivl_sel) - 1);
  assign cnt_load = CNT_W'(burst_size(cnt_sel) - 1);

  xqt_ctrl u_ctrl (
    .clk, .rst_n, .run, .mode, .btn, .sec_tick,
    .gap_expired, .left_zero,
    .fire, .start, .step, .halt, .start_single, .waiting,
    .exec_o, .busy_o
  );

  xqt_gap_timer #(.W(GAP_W)) u_gap (
    .clk, .rst_n, .clr(halt), .load(fire), .load_val(gap_load),
    .cnt(gap_cnt), .expired(gap_expired)
  );

  xqt_burst_counter #(.W(CNT_W)) u_left (
    .clk, .rst_n, .clr(halt), .load(start), .load_val(cnt_load),
    .dec(step), .last(left_zero)
  );
endmodule

// File: rtl/xqt_sequencer_chk.sv
module xqt_sequencer_chk #(
  parameter int BASE_CYCLES = 4000,
  parameter int GAP_W       = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sec_tick,
  input logic [1:0]       ivl_sel,
  input logic             exec_o,
  input logic             busy_o,
  input logic             start_single,
  input logic             waiting,
  input logic             left_zero,
  input logic [GAP_W-1:0] gap_cnt,
  input logic [1:0]       mode
);
  AST_EXEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> !exec_o); // R9

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!exec_o && !busy_o)); // R8

  AST_SINGLE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    start_single |=> exec_o); // R2

  AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && $stable(ivl_sel)) |->
      gap_cnt == GAP_W'(xqt_pkg::spacing_cycles(BASE_CYCLES, ivl_sel) - 1)); // R3

  AST_BURST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && $past(run) && $past(mode) != 2'd1 && $past(mode) != 2'd0)
      |-> $past(left_zero)); // R4

  AST_ARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && run && !sec_tick) |=> !exec_o); // R7
endmodule

bind xqt_sequencer xqt_sequencer_chk #(.BASE_CYCLES(BASE_CYCLES), .GAP_W(GAP_W)) u_chk (
  .clk, .rst_n, .run, .sec_tick, .ivl_sel, .exec_o, .busy_o,
  .start_single, .waiting, .left_zero, .gap_cnt, .mode
);

// File: tb/xqt_sequencer_bench.sv
module xqt_sequencer_bench;
  localparam int BASE = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_tick = 1'b0, run = 1'b0, btn = 1'b0;
  logic [1:0] mode = 2'd0, ivl_sel = 2'd0, cnt_sel = 2'd0;
  logic exec_o, busy_o;

  always #2 clk = ~clk;

  xqt_sequencer #(.BASE_CYCLES(BASE)) u_xqt_sequencer (
    .clk, .rst_n, .sec_tick, .mode, .ivl_sel, .cnt_sel, .run, .btn,
    .exec_o, .busy_o
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  cyc = 0;
  int  next_t, end_t;
  bit  m_active = 0, m_armed = 0, m_exec = 0, m_prev_run = 0;
  int  m_count = 0;
  int  lens[4] = '{2, 10, 100, 1000};

  function automatic int gap_of(logic [1:0] s);
    int g = BASE;
    repeat (s) g *= 10;
    return g;
  endfunction

  task automatic m_begin();
    m_active = 1; m_armed = 0; m_exec = 1;
    next_t = cyc + gap_of(ivl_sel);
    end_t  = (mode == 2'd1) ? -1 : cyc + lens[cnt_sel] * gap_of(ivl_sel);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_active = 0; m_armed = 0; m_exec = 0; m_prev_run = 0;
    end else begin
      m_exec = 0;
      if (!run) begin
        m_active = 0; m_armed = 0;
      end else if (m_active) begin
        if (mode == 2'd1 && btn) m_active = 0;
        else if (end_t >= 0 && cyc == end_t) m_active = 0;
        else if (cyc == next_t) begin
          m_exec = 1;
          next_t += gap_of(ivl_sel);
        end
      end else if (m_armed) begin
        if (sec_tick) m_begin();
      end else begin
        case (mode)
          2'd0: m_exec = run && !m_prev_run;
          2'd3: if (btn) m_armed = 1;
          default: if (btn) m_begin();
        endcase
      end
      m_prev_run = run;
      if (m_exec) m_count++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int n_exec = 0, streak = 0, max_streak = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "exec_o vs model", exec_o, m_exec);
      check(cur_req, "busy_o vs model", busy_o, m_active || m_armed || m_exec);
    end
    if (exec_o) begin
      n_exec++;
      streak++;
      if (streak > max_streak) max_streak = streak;
    end else streak = 0;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press();
    @(negedge clk) btn = 1'b1;
    @(negedge clk) btn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
  endtask

  // runs a mode 2 burst and checks length and duration (R3, R4, R5)
  task automatic burst(logic [1:0] iv, logic [1:0] cs, bit poke);
    int base_n, busy_cycles, guard;
    mode = 2'd2; ivl_sel = iv; cnt_sel = cs;
    base_n = n_exec;
    busy_cycles = 0;
    @(negedge clk) btn = 1'b1;
    @(negedge clk) btn = 1'b0;
    guard = 0;
    while (busy_o && guard < 100000) begin
      busy_cycles++;
      guard++;
      if (poke && busy_cycles == gap_of(iv) + 1) btn = 1'b1;
      @(negedge clk);
      btn = 1'b0;
    end
    check("R4", "strobes in burst", n_exec - base_n, lens[cs]);
    check("R3", "busy duration", busy_cycles, lens[cs] * gap_of(iv));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base_n;
    idle(3);
    check("R1", "exec in reset", exec_o, 0);
    check("R1", "busy in reset", busy_o, 0);
    @(negedge clk) rst_n = 1'b1;

    // R1: continuous off at power-up
    cur_req = "R1";
    mode = 2'd1; run = 1'b1;
    idle(20);
    check("R1", "no strobes without button", n_exec, 0);
    check("R1", "idle status", busy_o, 0);

    // R2: single mode
    cur_req = "R2";
    run = 1'b0; mode = 2'd0;
    idle(2);
    base_n = n_exec;
    run = 1'b1;
    idle(15);
    check("R2", "one strobe per rise", n_exec - base_n, 1);
    run = 1'b0; idle(2); run = 1'b1; idle(5);
    check("R2", "second rise", n_exec - base_n, 2);

    // R3/R4/R5: bursts across codes
    cur_req = "R5";
    burst(2'd0, 2'd0, 0);
    burst(2'd1, 2'd1, 0);
    burst(2'd0, 2'd3, 0);
    burst(2'd3, 2'd0, 0);
    burst(2'd2, 2'd2, 1);   // button mid-burst ignored (R5)

    // R6: continuous toggle
    cur_req = "R6";
    mode = 2'd1; ivl_sel = 2'd1;
    base_n = n_exec;
    press();
    idle(300);
    press();
    idle(3);
    check("R6", "stopped after second press", busy_o, 0);
    check("R6", "strobe count matches spacing", n_exec - base_n, 11);
    idle(100);
    check("R6", "no strobes after stop", n_exec - base_n, 11);

    // R7: second-aligned burst
    cur_req = "R7";
    mode = 2'd3; ivl_sel = 2'd0; cnt_sel = 2'd1;
    base_n = n_exec;
    press();
    idle(50);
    check("R7", "armed shows busy", busy_o, 1);
    check("R7", "no strobe before tick", n_exec - base_n, 0);
    tick();
    check("R7", "first strobe at tick", exec_o, 1);
    idle(40);
    check("R7", "burst length after tick", n_exec - base_n, 10);
    check("R7", "done", busy_o, 0);

    // R8: stop mid-burst, state discarded
    cur_req = "R8";
    mode = 2'd2; ivl_sel = 2'd1; cnt_sel = 2'd2;
    press();
    idle(100);
    @(negedge clk) run = 1'b0;
    @(negedge clk);
    check("R8", "busy cleared", busy_o, 0);
    check("R8", "exec cleared", exec_o, 0);
    base_n = n_exec;
    run = 1'b1;
    idle(200);
    check("R8", "burst not resumed", n_exec - base_n, 0);
    mode = 2'd1;
    press();
    idle(2);
    check("R8", "continuous starts cleanly after stop", busy_o, 1);
    @(negedge clk) run = 1'b0;
    idle(3);

    check("R9", "longest strobe", max_streak, 1);
    check("R9", "model count agrees", n_exec, m_count);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule